// File: doc/BRIEF.md
# Quadrature Chroma Demodulator

This block takes signed chrominance samples at the line-locked sample rate and splits them into two colour-difference components. Each accepted sample is multiplied by a cosine and a sine subcarrier. The two carriers are 90 degrees apart and come from a programmable phase accumulator. The increment of the accumulator is loaded to suit the colour standard in use.

Each product is rounded to 10 bits and then passes through a short symmetric low-pass FIR. A 2-bit select picks one of four fixed coefficient sets, from a straight pass-through to the narrowest response. Results leave the block with a valid strobe at a fixed pipeline latency, one strobe for each accepted sample. The filter select is expected to stay stable while samples are still in the pipeline.

Top module: `chroma_quad_demod`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) does the following: it drives out_vld low and both outputs to zero, clears the phase accumulator and both filter delay lines, and restores the increment to its default of 5505024.
- R2: A sample is accepted in a cycle with in_vld high. It uses phase index n, which is accumulator bits [23:18] as they stood before that sample. The accumulator then adds the increment modulo 2^24. Cycles with in_vld low leave the accumulator unchanged.
- R3: In a cycle with inc_load high, dto_inc is captured as the new increment. That value governs the steps of samples accepted in later cycles.
- R4: For phase index n, the sine carrier is round(255*sin(2*pi*(n+0.5)/64)) and the cosine carrier is round(255*cos(2*pi*(n+0.5)/64)). Both are 9-bit signed values built from a 16-entry quarter-wave magnitude table by mirroring.
- R5: Each product is floor((x*c+128)/256) as a 10-bit signed value, where x is the 9-bit signed input and c is the carrier. The I path uses the cosine carrier and the Q path uses the sine carrier.
- R6: Each path is a 5-tap symmetric FIR over its last five products, and bw_sel picks the taps. Code 0 gives (0,0,16,0,0), a pass-through. Code 1 gives (0,4,8,4,0). Code 2 gives (1,4,6,4,1). Code 3 gives (2,3,6,3,2). The output is floor((sum+8)/16).
- R7: The delay lines shift only when a product of an accepted sample arrives. Idle gaps between samples do not change any result.
- R8: out_vld is high for exactly one cycle per accepted sample, 4 clock cycles after the cycle in which that sample was presented, and never otherwise.
- R9: A reset while samples are in flight discards them, so no strobe appears for them. Results after the reset are computed from empty delay lines and phase index 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Sample on chroma_in is accepted this cycle |
| chroma_in | input | 9 | Signed chrominance sample |
| dto_inc | input | 24 | Phase increment to load |
| inc_load | input | 1 | Capture dto_inc as the increment |
| bw_sel | input | 2 | Low-pass response select, codes 0 to 3 |
| out_vld | output | 1 | Result strobe |
| demod_i | output | 10 | Signed filtered cosine-path result |
| demod_q | output | 10 | Signed filtered sine-path result |

## Verification
The hardest case to reach from the ports is the accumulator wrapping across 2^24 while a filter still holds products from before the wrap, followed by a reset that lands with samples half-way down the pipeline. The stimulus loads a unit index step so that every one of the 64 carrier phases is visited, and a negative step so that the accumulator wraps downwards. It spaces samples with idle gaps so that the delay lines see gaps, and it raises reset right behind a burst so that strobes of discarded samples would show up as unexpected results. Every carrier value is checked against a floating-point sine computed in the bench, using the pass-through response at full-scale positive and negative inputs.

// File: rtl/cqd_pkg.sv
package cqd_pkg;
  localparam int SMP_W  = 9;
  localparam int ACC_W  = 24;
  localparam int PH_W   = 6;
  localparam int QTR_W  = PH_W - 2;
  localparam int TRIG_W = 9;
  localparam int MIX_W  = 10;
  localparam int MIX_SH = 8;
  localparam int TAPS   = 5;
  localparam int MID    = TAPS / 2;
  localparam int FIR_SH = 4;
  localparam int NCH    = 2;
  localparam int QUARTER = 1 << QTR_W;

  typedef logic signed [SMP_W-1:0]  smp_t;
  typedef logic signed [TRIG_W-1:0] trig_t;
  typedef logic signed [MIX_W-1:0]  mix_t;

  typedef enum logic [1:0] {
    BW_FULL   = 2'd0,
    BW_WIDE   = 2'd1,
    BW_MED    = 2'd2,
    BW_NARROW = 2'd3
  } bw_e;

  // quarter-wave magnitude at offset (k+0.5)/16 of a quarter turn, scale 255
  function automatic logic [7:0] qtr_mag(input logic [QTR_W-1:0] k);
    case (k)
      4'd0:    return 8'd13;
      4'd1:    return 8'd37;
      4'd2:    return 8'd62;
      4'd3:    return 8'd86;
      4'd4:    return 8'd109;
      4'd5:    return 8'd131;
      4'd6:    return 8'd152;
      4'd7:    return 8'd171;
      4'd8:    return 8'd189;
      4'd9:    return 8'd205;
      4'd10:   return 8'd219;
      4'd11:   return 8'd231;
      4'd12:   return 8'd240;
      4'd13:   return 8'd247;
      4'd14:   return 8'd252;
      default: return 8'd255;
    endcase
  endfunction

  // full-turn sine from the quarter table: odd quadrants mirror, upper half negates
  function automatic trig_t trig_at(input logic [PH_W-1:0] ph);
    logic [QTR_W-1:0] k;
    logic [7:0]       m;
    k = ph[PH_W-2] ? ~ph[QTR_W-1:0] : ph[QTR_W-1:0];
    m = qtr_mag(k);
    if (ph[PH_W-1]) return -trig_t'({1'b0, m});
    return trig_t'({1'b0, m});
  endfunction

  // product rounded half-up and scaled back to MIX_W bits
  function automatic mix_t mix_round(input smp_t x, input trig_t t);
    int p;
    p = (int'(x) * int'(t) + (1 << (MIX_SH - 1))) >>> MIX_SH;
    return mix_t'(p);
  endfunction

  // symmetric tap weight chosen by distance from the centre tap
  function automatic int fir_coef(input bw_e bw, input int tap);
    int d;
    d = (tap > MID) ? tap - MID : MID - tap;
    case (bw)
      BW_FULL: return (d == 0) ? 16 : 0;
      BW_WIDE: return (d == 0) ? 8 : ((d == 1) ? 4 : 0);
      BW_MED:  return (d == 0) ? 6 : ((d == 1) ? 4 : 1);
      default: return (d == 0) ? 6 : ((d == 1) ? 3 : 2);
    endcase
  endfunction

  function automatic mix_t fir_round(input int s);
    int r;
    r = (s + (1 << (FIR_SH - 1))) >>> FIR_SH;
    return mix_t'(r);
  endfunction
endpackage

// File: rtl/cqd_phase_dto.sv
module cqd_phase_dto
  import cqd_pkg::*;
#(
  parameter int               AW      = ACC_W,
  parameter logic [AW-1:0]    DEF_INC = '0
)(
  input  logic          clk,
  input  logic          rst,
  input  logic          step_en,
  input  logic          inc_load,
  input  logic [AW-1:0] inc_in,
  output logic [AW-1:0] acc_o
);
  logic [AW-1:0] acc_q;
  logic [AW-1:0] inc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      inc_q <= DEF_INC;
    end else begin
      if (inc_load) inc_q <= inc_in;
      if (step_en)  acc_q <= acc_q + inc_q;
    end
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/cqd_mixer.sv
module cqd_mixer
  import cqd_pkg::*;
#(
  parameter int PH_OFS = 0
)(
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  smp_t            x,
  input  logic [PH_W-1:0] ph,
  output trig_t           trig_o,
  output mix_t            mix_o
);
  logic [PH_W-1:0] ph_eff;

  assign ph_eff = ph + PH_W'(PH_OFS);
  assign trig_o = trig_at(ph_eff);

  always_ff @(posedge clk) begin
    if (rst)     mix_o <= '0;
    else if (en) mix_o <= mix_round(x, trig_o);
  end
endmodule

// File: rtl/cqd_fir.sv
module cqd_fir
  import cqd_pkg::*;
#(
  parameter int N = TAPS
)(
  input  logic clk,
  input  logic rst,
  input  logic shift_en,
  input  logic out_en,
  input  mix_t din,
  input  bw_e  bw,
  output mix_t dout
);
  mix_t line [N];
  int   sum_c;

  for (genvar t = 0; t < N; t++) begin : g_tap
    if (t == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst)           line[t] <= '0;
        else if (shift_en) line[t] <= din;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst)           line[t] <= '0;
        else if (shift_en) line[t] <= line[t-1];
      end
    end
  end

  always_comb begin
    sum_c = 0;
    for (int t = 0; t < N; t++) begin
      sum_c = sum_c + int'(line[t]) * fir_coef(bw, t);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         dout <= '0;
    else if (out_en) dout <= fir_round(sum_c);
  end
endmodule

// File: rtl/chroma_quad_demod.sv
module chroma_quad_demod
  import cqd_pkg::*;
#(
  parameter logic [ACC_W-1:0] DEF_INC = 24'd5505024
)(
  input  logic               clk,
  input  logic               rst,
  input  logic               in_vld,
  input  logic [SMP_W-1:0]   chroma_in,
  input  logic [ACC_W-1:0]   dto_inc,
  input  logic               inc_load,
  input  logic [1:0]         bw_sel,
  output logic               out_vld,
  output logic [MIX_W-1:0]   demod_i,
  output logic [MIX_W-1:0]   demod_q
);
  logic [ACC_W-1:0] acc_w;
  logic             s0_vld;
  smp_t             s0_x;
  logic [PH_W-1:0]  s0_ph;
  logic             mix_vld_w;
  logic             line_vld;
  trig_t            trig_w [NCH];
  mix_t             mix_w  [NCH];
  mix_t             fir_w  [NCH];
  trig_t            cos_w, sin_w;
  mix_t             mix_i_w, mix_q_w;
  bw_e              bw_w;

  assign bw_w = bw_e'(bw_sel);

  cqd_phase_dto #(.AW(ACC_W), .DEF_INC(DEF_INC)) u_dto (
    .clk     (clk),
    .rst     (rst),
    .step_en (in_vld),
    .inc_load(inc_load),
    .inc_in  (dto_inc),
    .acc_o   (acc_w)
  );

  // capture stage: sample and the phase it is mixed with
  always_ff @(posedge clk) begin
    if (rst) begin
      s0_vld <= 1'b0;
      s0_x   <= '0;
      s0_ph  <= '0;
    end else begin
      s0_vld <= in_vld;
      if (in_vld) begin
        s0_x  <= smp_t'(chroma_in);
        s0_ph <= acc_w[ACC_W-1 -: PH_W];
      end
    end
  end

  // valid pipeline: product, delay line, output register
  always_ff @(posedge clk) begin
    if (rst) begin
      mix_vld_w <= 1'b0;
      line_vld  <= 1'b0;
      out_vld   <= 1'b0;
    end else begin
      mix_vld_w <= s0_vld;
      line_vld  <= mix_vld_w;
      out_vld   <= line_vld;
    end
  end

  // channel 0: cosine (phase advanced a quarter turn), channel 1: sine
  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    cqd_mixer #(.PH_OFS((ch == 0) ? QUARTER : 0)) u_mix (
      .clk   (clk),
      .rst   (rst),
      .en    (s0_vld),
      .x     (s0_x),
      .ph    (s0_ph),
      .trig_o(trig_w[ch]),
      .mix_o (mix_w[ch])
    );

    cqd_fir #(.N(TAPS)) u_fir (
      .clk     (clk),
      .rst     (rst),
      .shift_en(mix_vld_w),
      .out_en  (line_vld),
      .din     (mix_w[ch]),
      .bw      (bw_w),
      .dout    (fir_w[ch])
    );
  end

  assign cos_w   = trig_w[0];
  assign sin_w   = trig_w[1];
  assign mix_i_w = mix_w[0];
  assign mix_q_w = mix_w[1];
  assign demod_i = fir_w[0];
  assign demod_q = fir_w[1];
endmodule

// File: rtl/cqd_chk.sv
module cqd_chk
  import cqd_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             in_vld,
  input logic             out_vld,
  input logic [MIX_W-1:0] demod_i,
  input logic [MIX_W-1:0] demod_q,
  input logic [ACC_W-1:0] acc,
  input trig_t            cos_t,
  input trig_t            sin_t,
  input logic             mix_vld,
  input mix_t             mix_i,
  input mix_t             mix_q
);
  int pwr;
  always_comb pwr = int'(cos_t) * int'(cos_t) + int'(sin_t) * int'(sin_t);

  // R1: reset leaves a quiet, zeroed output
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!out_vld && demod_i == '0 && demod_q == '0));

  // R2: idle cycles do not move the phase
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> $stable(acc));

  // R4: the two carriers stay in quadrature (near-unit combined power)
  a_r4_quadrature: assert property (@(posedge clk) disable iff (rst)
    (pwr >= 64000 && pwr <= 66000));

  // R5: rounded products never exceed the carrier scale
  a_r5_mix_range: assert property (@(posedge clk) disable iff (rst)
    mix_vld |-> (int'(mix_i) <= 255 && int'(mix_i) >= -255 &&
                 int'(mix_q) <= 255 && int'(mix_q) >= -255));

  // R8: each accepted sample yields a strobe four cycles on
  a_r8_latency_hit: assert property (@(posedge clk) disable iff (rst)
    in_vld |-> ##4 out_vld);

  // R8: no strobe without an accepted sample four cycles before
  a_r8_latency_miss: assert property (@(posedge clk) disable iff (rst)
    !in_vld |-> ##4 !out_vld);
endmodule

bind chroma_quad_demod cqd_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .in_vld (in_vld),
  .out_vld(out_vld),
  .demod_i(demod_i),
  .demod_q(demod_q),
  .acc    (acc_w),
  .cos_t  (cos_w),
  .sin_t  (sin_w),
  .mix_vld(mix_vld_w),
  .mix_i  (mix_i_w),
  .mix_q  (mix_q_w)
);

// File: tb/sim_chroma_quad_demod.sv
`timescale 1ns/1ps
module sim_chroma_quad_demod;
  localparam int DEF_STEP = 5505024;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_vld;
  logic [8:0]  chroma_in;
  logic [23:0] dto_inc;
  logic        inc_load;
  logic [1:0]  bw_sel;
  logic        out_vld;
  logic [9:0]  demod_i;
  logic [9:0]  demod_q;

  always #5 clk = ~clk;

  chroma_quad_demod u0 (
    .clk(clk), .rst(rst), .in_vld(in_vld), .chroma_in(chroma_in),
    .dto_inc(dto_inc), .inc_load(inc_load), .bw_sel(bw_sel),
    .out_vld(out_vld), .demod_i(demod_i), .demod_q(demod_q)
  );

  typedef struct { int i; int q; string tag; } exp_t;
  exp_t expq[$];
  exp_t e;

  int    checks = 0;
  int    errors = 0;
  bit    done   = 1'b0;
  int    m_acc, m_inc, m_bw;
  int    m_li[5];
  int    m_lq[5];
  string cur_tag;

  // tap weights restated from R6, indexed [code][tap]
  int wts[4][5] = '{'{0,0,16,0,0}, '{0,4,8,4,0}, '{1,4,6,4,1}, '{2,3,6,3,2}};

  function automatic int ref_carrier(input int n, input bit use_cos);
    real a, r;
    a = 2.0 * 3.14159265358979 * (real'(n) + 0.5) / 64.0;
    r = 255.0 * (use_cos ? $cos(a) : $sin(a));
    return (r >= 0.0) ? $rtoi(r + 0.5) : -$rtoi(-r + 0.5);
  endfunction

  function automatic int ref_prod(input int x, input int c);
    return (x * c + 128) >>> 8;
  endfunction

  task automatic model_clear();
    m_acc = 0;
    m_inc = DEF_STEP;
    for (int t = 0; t < 5; t++) begin m_li[t] = 0; m_lq[t] = 0; end
    expq.delete();
  endtask

  task automatic push_model(input int x);
    int n, si, sq;
    exp_t ne;
    n = (m_acc >> 18) & 63;
    for (int t = 4; t > 0; t--) begin m_li[t] = m_li[t-1]; m_lq[t] = m_lq[t-1]; end
    m_li[0] = ref_prod(x, ref_carrier(n, 1'b1));
    m_lq[0] = ref_prod(x, ref_carrier(n, 1'b0));
    si = 0; sq = 0;
    for (int t = 0; t < 5; t++) begin
      si += wts[m_bw][t] * m_li[t];
      sq += wts[m_bw][t] * m_lq[t];
    end
    ne.i = (si + 8) >>> 4;
    ne.q = (sq + 8) >>> 4;
    ne.tag = cur_tag;
    expq.push_back(ne);
    m_acc = (m_acc + m_inc) & 24'hFFFFFF;
  endtask

  task automatic drive(input int x, input bit v);
    @(negedge clk);
    in_vld    = v;
    chroma_in = x[8:0];
    if (v) push_model(x);
  endtask

  task automatic load_step(input int s);
    @(negedge clk);
    in_vld   = 1'b0;
    inc_load = 1'b1;
    dto_inc  = s[23:0];
    m_inc    = s;
    @(negedge clk);
    inc_load = 1'b0;
  endtask

  task automatic drain(input string tag);
    repeat (6) drive(0, 1'b0);
    checks++;
    if (expq.size() != 0) begin
      errors++;
      $display("FAIL %s missing strobes actual=%0d expected=0", tag, expq.size());
      expq.delete();
    end
  endtask

  task automatic set_bw(input int b);
    @(negedge clk);
    bw_sel = b[1:0];
    m_bw   = b;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst    = 1'b1;
    in_vld = 1'b0;
    model_clear();
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic check_quiet(input string tag);
    checks++;
    if (out_vld !== 1'b0 || demod_i !== 10'd0 || demod_q !== 10'd0) begin
      errors++;
      $display("FAIL %s reset state actual=%b/%0d/%0d expected=0/0/0",
               tag, out_vld, $signed(demod_i), $signed(demod_q));
    end
  endtask

  // scoreboard monitor, sampling away from the active edge
  always @(posedge clk) begin
    #3;
    if (rst === 1'b0 && out_vld === 1'b1) begin
      checks++;
      if (expq.size() == 0) begin
        errors++;
        $display("FAIL R8 unexpected strobe actual=1 expected=0");
      end else begin
        e = expq.pop_front();
        if (int'($signed(demod_i)) != e.i || int'($signed(demod_q)) != e.q) begin
          errors++;
          $display("FAIL %s actual=%0d,%0d expected=%0d,%0d",
                   e.tag, $signed(demod_i), $signed(demod_q), e.i, e.q);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; in_vld = 1'b0; chroma_in = '0; dto_inc = '0;
    inc_load = 1'b0; bw_sel = 2'd0; m_bw = 0; cur_tag = "R1";
    model_clear();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_quiet("R1");

    // R1 / R2: default step, first sample at phase 0
    cur_tag = "R1";
    for (int k = 0; k < 8; k++) drive(200 - 30 * k, 1'b1);
    drain("R1");

    // R4: unit index step sweeps all 64 phases, pass-through filter
    cur_tag = "R4";
    load_step(1 << 18);
    for (int k = 0; k < 70; k++) drive(255, 1'b1);
    drain("R4");

    // R5: most negative input across all phases
    cur_tag = "R5";
    for (int k = 0; k < 66; k++) drive(-256, 1'b1);
    drain("R5");

    // R2: negative step, accumulator wraps below zero
    cur_tag = "R2";
    load_step(24'hFC0000);
    for (int k = 0; k < 20; k++) drive(k * 23 - 200, 1'b1);
    drain("R2");

    // R3: zero step freezes the phase
    cur_tag = "R3";
    load_step(0);
    for (int k = 0; k < 10; k++) drive(150 - 40 * k, 1'b1);
    drain("R3");

    // R6: every filter code with a colour-burst-like step
    load_step(4448988);
    for (int b = 1; b < 4; b++) begin
      set_bw(b);
      cur_tag = "R6";
      for (int k = 0; k < 24; k++) drive((k % 2 == 0) ? 220 : -220, 1'b1);
      for (int k = 0; k < 16; k++) drive(k * 30 - 240, 1'b1);
      drain("R6");
    end

    // R7: idle gaps between samples
    set_bw(2);
    cur_tag = "R7";
    for (int k = 0; k < 20; k++) begin
      drive(180 - 17 * k, 1'b1);
      repeat (k % 4) drive(99, 1'b0);
    end
    drain("R7");

    // R9: reset with samples in flight
    set_bw(3);
    cur_tag = "R9";
    for (int k = 0; k < 6; k++) drive(250, 1'b1);
    do_reset();
    @(negedge clk);
    check_quiet("R9");
    cur_tag = "R9";
    for (int k = 0; k < 12; k++) drive(-120 + 21 * k, 1'b1);
    drain("R9");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule